// File: doc/BRIEF.md
# Interrupt Remap Table Pointer Control

This block is the register front end of an interrupt remapping unit. Software reaches it through a 32-bit register port. The port holds a 64-bit table-address register split into two words, a global command register and a global status register. Software first programs the table address, the size code and the extended-mode flag. It then writes the set-pointer command. The block answers with a status handshake: the completion bit drops, stays low for a programmable number of cycles, and rises again. At that point the active copies of the table base page, the entry count and the extended-mode enable are valid for the translation logic downstream.

A command write is decoded against the current status. The one-shot bits are masked out of the status first, and the result is XORed with the written word to find the changed fields. A write that changes nothing is dropped. A write that changes more than one field raises a sticky protocol-error flag, but the write still takes effect. The active copies are reloaded only when the programmed base page or entry count differs from the active one, so a change of the extended-mode flag alone is not taken.

Top module: `remap_ptr_ctrl`

## Requirements
- R1: After reset, the active base page, entry count, extended-mode enable, status word and protocol-error flag are all zero.
- R2: The table-address low word is at offset 0xB8 and the high word is at 0xBC. A read at either offset returns the value last written there, with read data valid on the cycle after the read strobe.
- R3: A write or read whose address has bits [1:0] not zero is ignored. Register contents, status and read data are unchanged.
- R4: A read of the command register (offset 0x40) returns zero. A read of the status register (offset 0x44) returns the current status word.
- R5: A set-pointer command (command bit 24) clears status bit 24 on the cycle after the write. The bit stays clear for CLR_CYCLES cycles (default 1) and then sets.
- R6: On completion, the active base page takes address bits [63:12] and the entry count becomes 2^(S+1), where S is address bits [3:0]. The extended-mode enable takes address bit 11.
- R7: The active copies are reloaded only when the programmed base page or entry count differs from the active copy. A change of bit 11 alone leaves the extended-mode enable unchanged.
- R8: Writes to the address register after completion do not change the active outputs until the next set-pointer command.
- R9: The changed set is (status AND 0x96FFFFFF) XOR written word. When it is zero, the command write has no effect.
- R10: When the changed set is non-zero, the status bits kept by mask 0x96FFFFFF take the written value. Bits 24, 27, 29 and 30 are one-shot bits and never read back from the command.
- R11: A command write whose changed set has more than one bit sets the protocol-error flag. The flag stays set until reset.
- R12: A command write with bit 24 clear starts no handshake, and status bit 24 keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after rd_en_i |
| tbl_page_o | output | 52 | Active table base page number |
| tbl_entries_o | output | 17 | Active table entry count |
| ext_mode_o | output | 1 | Active extended-mode enable |
| status_o | output | 32 | Global status word |
| proto_err_o | output | 1 | Sticky flag for a command write that changes several fields |

## Verification
The hardest case to reach is a set-pointer command that must not reload anything. The bench gets there by keeping the base page and size the same and changing only bit 11, then checking that the extended-mode output stays as it was. A second hard case is a command that repeats a persistent bit already set in status together with bit 24. That write changes only one field and must not be flagged. The bench first sets a persistent bit and then reissues the pointer command in that form, which also shows that the one-shot mask keeps status bit 24 out of the changed set.

// File: rtl/remap_ptr_pkg.sv
package remap_ptr_pkg;
  localparam int REG_DW     = 32;
  localparam int TBL_AW     = 64;
  localparam int PAGE_SHIFT = 12;
  localparam int PAGE_W     = TBL_AW - PAGE_SHIFT;
  localparam int SIZE_W     = 4;
  localparam int ENT_W      = (1 << SIZE_W) + 1;
  localparam int EXT_BIT    = 11;
  localparam int SETPTR_BIT = 24;

  localparam logic [7:0] OFF_TBL_LO = 8'hB8;
  localparam logic [7:0] OFF_TBL_HI = 8'hBC;
  localparam logic [7:0] OFF_CMD    = 8'h40;
  localparam logic [7:0] OFF_STS    = 8'h44;

  // bits kept across command writes; zeros are one-shot
  localparam logic [REG_DW-1:0] PERSIST_MASK = 32'h96FF_FFFF;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [SIZE_W-1:0] size;
    logic              ext;
  } tbl_cfg_t;
endpackage

// File: rtl/remap_ptr_regs.sv
module remap_ptr_regs
  import remap_ptr_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic [REG_DW-1:0] status_i,
  output logic              cmd_wr_o,
  output tbl_cfg_t          cfg_o,
  output logic [REG_DW-1:0] rdata_o
);
  logic              aligned;
  logic [TBL_AW-1:0] tbl_q;
  logic [REG_DW-1:0] rdata_q;

  assign aligned = (addr_i[1:0] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= '0;
    end else if (wr_en_i && aligned) begin
      if (addr_i == REG_AW'(OFF_TBL_LO)) tbl_q[REG_DW-1:0]      <= wdata_i;
      if (addr_i == REG_AW'(OFF_TBL_HI)) tbl_q[TBL_AW-1:REG_DW] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_en_i && aligned) begin
      if (addr_i == REG_AW'(OFF_TBL_LO))      rdata_q <= tbl_q[REG_DW-1:0];
      else if (addr_i == REG_AW'(OFF_TBL_HI)) rdata_q <= tbl_q[TBL_AW-1:REG_DW];
      else if (addr_i == REG_AW'(OFF_STS))    rdata_q <= status_i;
      else                                    rdata_q <= '0;
    end
  end

  assign cmd_wr_o   = wr_en_i && aligned && (addr_i == REG_AW'(OFF_CMD));
  assign cfg_o.page = tbl_q[TBL_AW-1:PAGE_SHIFT];
  assign cfg_o.size = tbl_q[SIZE_W-1:0];
  assign cfg_o.ext  = tbl_q[EXT_BIT];
  assign rdata_o    = rdata_q;

  // R3
  unaligned_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !aligned) |=> $stable(tbl_q));
  // R3
  unaligned_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !aligned) |=> $stable(rdata_q));
endmodule

// File: rtl/remap_ptr_cmd.sv
module remap_ptr_cmd
  import remap_ptr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic [REG_DW-1:0] status_i,
  output logic [REG_DW-1:0] persist_o,
  output logic              start_o,
  output logic              err_o
);
  logic [REG_DW-1:0] persist_q;
  logic [REG_DW-1:0] changed;
  logic              any_chg;
  logic              multi_chg;
  logic              err_q;

  assign changed   = (status_i & PERSIST_MASK) ^ wdata_i;
  assign any_chg   = |changed;
  assign multi_chg = |(changed & (changed - REG_DW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      persist_q <= '0;
      err_q     <= 1'b0;
    end else if (cmd_wr_i && any_chg) begin
      persist_q <= wdata_i & PERSIST_MASK;
      if (multi_chg) err_q <= 1'b1;
    end
  end

  assign start_o   = cmd_wr_i && any_chg && wdata_i[SETPTR_BIT];
  assign persist_o = persist_q;
  assign err_o     = err_q;

  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  // R9
  no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && (wdata_i == (status_i & PERSIST_MASK))) |=> ($stable(persist_q) && $stable(err_q)));
endmodule

// File: rtl/remap_ptr_load.sv
module remap_ptr_load
  import remap_ptr_pkg::*;
#(
  parameter int CLR_CYCLES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  tbl_cfg_t          cfg_i,
  output logic              done_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [ENT_W-1:0]  entries_o,
  output logic              ext_o
);
  localparam int CW = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;

  logic              busy_q;
  logic [CW-1:0]     cnt_q;
  logic              done_q;
  logic [PAGE_W-1:0] page_q;
  logic [ENT_W-1:0]  ent_q;
  logic              ext_q;
  logic [ENT_W-1:0]  prog_ent;
  logic              differs;

  assign prog_ent = ENT_W'(1) << (int'(cfg_i.size) + 1);
  assign differs  = (cfg_i.page != page_q) || (prog_ent != ent_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      page_q <= '0;
      ent_q  <= '0;
      ext_q  <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == CW'(CLR_CYCLES - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (differs) begin
          page_q <= cfg_i.page;
          ent_q  <= prog_ent;
          ext_q  <= cfg_i.ext;
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign done_o    = done_q;
  assign page_o    = page_q;
  assign entries_o = ent_q;
  assign ext_o     = ext_q;

  // R5
  clear_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_q);
  // R7
  reload_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(page_q) || !$stable(ent_q)) |-> $rose(done_q));
  // R8
  ext_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ext_q) |-> $rose(done_q));
endmodule

// File: rtl/remap_ptr_ctrl.sv
module remap_ptr_ctrl
  import remap_ptr_pkg::*;
#(
  parameter int REG_AW     = 8,
  parameter int CLR_CYCLES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic [PAGE_W-1:0] tbl_page_o,
  output logic [ENT_W-1:0]  tbl_entries_o,
  output logic              ext_mode_o,
  output logic [REG_DW-1:0] status_o,
  output logic              proto_err_o
);
  logic              cmd_wr;
  logic              start;
  logic              done;
  logic [REG_DW-1:0] persist;
  logic [REG_DW-1:0] status;
  tbl_cfg_t          cfg;

  assign status = persist | (REG_DW'(done) << SETPTR_BIT);

  remap_ptr_regs #(.REG_AW(REG_AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .status_i (status),
    .cmd_wr_o (cmd_wr),
    .cfg_o    (cfg),
    .rdata_o  (rdata_o)
  );

  remap_ptr_cmd u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_wr_i  (cmd_wr),
    .wdata_i   (wdata_i),
    .status_i  (status),
    .persist_o (persist),
    .start_o   (start),
    .err_o     (proto_err_o)
  );

  remap_ptr_load #(.CLR_CYCLES(CLR_CYCLES)) u_load (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cfg_i     (cfg),
    .done_o    (done),
    .page_o    (tbl_page_o),
    .entries_o (tbl_entries_o),
    .ext_o     (ext_mode_o)
  );

  assign status_o = status;

  // R12
  no_cmd_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start && !$past(start) && $past(rst_ni)) |-> !$fell(done));
endmodule

// File: tb/remap_ptr_ctrl_tb.sv
`timescale 1ns/1ps
module remap_ptr_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [51:0] tbl_page_o;
  logic [16:0] tbl_entries_o;
  logic        ext_mode_o;
  logic [31:0] status_o;
  logic        proto_err_o;

  remap_ptr_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .tbl_page_o(tbl_page_o), .tbl_entries_o(tbl_entries_o),
    .ext_mode_o(ext_mode_o), .status_o(status_o), .proto_err_o(proto_err_o)
  );

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    int          sel;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done_run = 1'b0;

  function automatic logic [63:0] pick(int sel);
    case (sel)
      0: return 64'(rdata_o);
      1: return 64'(tbl_page_o);
      2: return 64'(tbl_entries_o);
      3: return 64'(ext_mode_o);
      4: return 64'(status_o);
      default: return 64'(proto_err_o);
    endcase
  endfunction

  task automatic expect_now(int sel, logic [63:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it = q.pop_front();
        act = pick(it.sel);
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic outs(logic [51:0] pg, logic [16:0] en, logic ex, string tag);
    expect_now(1, 64'(pg), tag);
    expect_now(2, 64'(en), tag);
    expect_now(3, 64'(ex), tag);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    outs(52'h0, 17'h0, 1'b0, "R1 reset outputs");
    expect_now(4, 64'h0, "R1 reset status");
    expect_now(5, 64'h0, "R1 reset err");

    bus_wr(8'hB8, 32'h1234_5803);
    bus_wr(8'hBC, 32'h0000_00AB);
    bus_rd(8'hB8); expect_now(0, 64'h1234_5803, "R2 low word");
    bus_rd(8'hBC); expect_now(0, 64'h0000_00AB, "R2 high word");
    bus_wr(8'hB9, 32'hFFFF_FFFF);
    bus_rd(8'hBA); expect_now(0, 64'h0000_00AB, "R3 unaligned read");
    bus_rd(8'hB8); expect_now(0, 64'h1234_5803, "R3 unaligned write");
    bus_rd(8'h40); expect_now(0, 64'h0, "R4 command reads zero");
    bus_rd(8'h44); expect_now(0, 64'h0, "R4 status read");

    // first pointer command
    bus_wr(8'h40, 32'h0100_0000);
    expect_now(4, 64'h0, "R5 bit clear during window");
    @(negedge clk_i);
    expect_now(4, 64'h0100_0000, "R5 bit set after window");
    outs(52'hAB_12345, 17'd16, 1'b1, "R6 first load");
    expect_now(5, 64'h0, "R11 single field");
    bus_rd(8'h40); expect_now(0, 64'h0, "R4 command reads zero");
    bus_rd(8'h44); expect_now(0, 64'h0100_0000, "R4 status read");

    // only the extended-mode bit changes: no reload
    bus_wr(8'hB8, 32'h1234_5003);
    bus_wr(8'h40, 32'h0100_0000);
    expect_now(4, 64'h0, "R5 clear from set state");
    @(negedge clk_i);
    expect_now(4, 64'h0100_0000, "R5 set again");
    outs(52'hAB_12345, 17'd16, 1'b1, "R7 ext-only change ignored");

    // address writes without command do not reach outputs
    bus_wr(8'hB8, 32'h0000_0007);
    bus_wr(8'hBC, 32'h0000_0000);
    outs(52'hAB_12345, 17'd16, 1'b1, "R8 outputs held");
    bus_wr(8'h40, 32'h0100_0000);
    @(negedge clk_i);
    outs(52'h0, 17'd256, 1'b0, "R6 R7 reload on differ");

    // persistent field
    bus_wr(8'h40, 32'h0200_0000);
    expect_now(4, 64'h0300_0000, "R10 R12 persistent bit, no handshake");
    expect_now(5, 64'h0, "R11 single field");
    bus_wr(8'h40, 32'h0200_0000);
    expect_now(4, 64'h0300_0000, "R9 no change status");
    expect_now(5, 64'h0, "R9 no change err");

    // boundary sizes, serialized write keeping bit 25
    bus_wr(8'hB8, 32'hFFFF_F800);
    bus_wr(8'hBC, 32'hFFFF_FFFF);
    bus_wr(8'h40, 32'h0300_0000);
    expect_now(4, 64'h0200_0000, "R5 R10 clear keeps persistent");
    expect_now(5, 64'h0, "R11 serialized write not flagged");
    @(negedge clk_i);
    expect_now(4, 64'h0300_0000, "R5 set with persistent");
    outs(52'hF_FFFF_FFFF_FFFF, 17'd2, 1'b1, "R6 size code 0");
    bus_wr(8'hB8, 32'h0000_000F);
    bus_wr(8'h40, 32'h0300_0000);
    @(negedge clk_i);
    outs(52'hF_FFFF_FFF0_0000, 17'd65536, 1'b0, "R6 size code 15");

    // several fields at once
    bus_wr(8'h40, 32'h0400_0001);
    expect_now(5, 64'h1, "R11 multi-field flagged");
    expect_now(4, 64'h0500_0001, "R10 R12 status after multi write");
    bus_wr(8'h40, 32'h0400_0001);
    expect_now(5, 64'h1, "R11 flag sticky");
    bus_wr(8'h42, 32'h0000_0000);
    expect_now(4, 64'h0500_0001, "R3 unaligned command ignored");
    bus_rd(8'h44); expect_now(0, 64'h0500_0001, "R4 status read");

    @(negedge clk_i);
    #2;
    done_run = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done_run) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule